// File: doc/BRIEF.md
# DTMF Tone Burst Synthesizer

This block builds the digital sample stream for a dual-tone multi-frequency transmitter. A 4-bit key code picks one of four low-group (row) frequencies and one of four high-group (column) frequencies. Each group has its own divider. The divider counts a code-selected number of clock cycles and then moves a 5-bit phase index one step through a 32-step sine table. The row sample is scaled down to about 0.79 of full size, which leaves the column tone about 2 dB louder. The two samples are added into a registered signed word for an external DAC. A value of zero stands for the mid-scale idle level.

A three-state sequencer (`ST_IDLE`, `ST_BURST`, `ST_PAUSE`) handles timed bursts. In burst mode a write moves the sequencer from `ST_IDLE` to `ST_BURST`, or back to `ST_BURST` from either timed state. When the burst timer expires the sequencer moves from `ST_BURST` to `ST_PAUSE`. When the pause timer expires it moves from `ST_PAUSE` to `ST_IDLE` and raises the ready flag. If burst mode is switched off, any state moves to `ST_IDLE`. When burst mode is off, the tone plays continuously while the output enable is set. The default burst length is 182557 cycles of the 3.579545 MHz clock, about 51 ms. Call-progress mode doubles both the burst and the pause.

Top module: `dtmf_burst_gen`

## Requirements
- R1: The key code selects the row/column divisor pair as follows. Codes 1–9 give row (code-1)/3 and column (code-1)%3. Code 10 gives row 3, column 1. Code 11 gives row 3, column 0. Code 12 gives row 3, column 2. Codes 13–15 give row code-13, column 3. Code 0 gives row 3, column 3. The row divisors are 160/146/132/118 and the column divisors are 92/84/76/68, each equal to round(3579545 / (32 × achieved frequency)).
- R2: Each channel's phase starts at 0 on every write and advances by one (mod 32) after each run of `divisor` active cycles. Its sample is round(127·sin(2πk/32)).
- R3: After clock edge n (n = 1 is the first edge after the write edge), `pcm_out` equals col + floor(row·101/128). This uses the phases reached after n-1 active edges. The result is 9-bit two's complement.
- R4: `pcm_out` is 0 whenever `tone_en` is low, the sequencer is idle in burst mode, or the sequencer is pausing.
- R5: With `single_tone` high, only the column tone is output if `col_sel` = 1, and only the row tone if `col_sel` = 0.
- R6: In burst mode, a write produces tone for BURST_CYC edges and then silence for BURST_CYC edges. `tx_ready` goes high at edge 2·BURST_CYC after the write.
- R7: With `cp_mode` high, the burst and the pause each last 2·BURST_CYC edges.
- R8: `tx_ready` is cleared by a write and by `burst_mode` being low. It is 0 after reset.
- R9: With `burst_mode` low, the code from the last write plays for as long as `tone_en` is high.
- R10: A write during a burst or a pause restarts the burst with the new code and restarts the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 3.579545 MHz clock |
| rst_n | input | 1 | asynchronous active-low reset |
| wr_en | input | 1 | one-cycle write strobe for the key code |
| wr_code | input | 4 | key code |
| tone_en | input | 1 | tone output enable |
| burst_mode | input | 1 | 1 = timed burst/pause, 0 = continuous |
| cp_mode | input | 1 | doubles the burst and pause length |
| single_tone | input | 1 | output one group only |
| col_sel | input | 1 | in single-tone mode, 1 = column, 0 = row |
| pcm_out | output | 9 | signed sample, 0 = mid-scale |
| tx_ready | output | 1 | pause finished, ready for the next code |

## Verification
A wrong divisor or a wrong phase step shows up at `pcm_out` within one table step. A wrong divisor is seen when the first nonzero sample arrives early or late, which takes at most 161 cycles after a write. A sequencer that leaves `ST_BURST` or `ST_PAUSE` one edge too early or too late shows up at exactly one edge. Either the tone stops or continues at edge BURST_CYC, or `tx_ready` rises off edge 2·BURST_CYC. The sample stream is therefore compared edge by edge against an arithmetic model, as is the ready flag.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;
    localparam int DIV_W = 8;
    localparam int PH_W  = 5;

    typedef enum logic [1:0] {ST_IDLE, ST_BURST, ST_PAUSE} burst_st_t;

    typedef struct packed {
        logic [1:0] row;
        logic [1:0] col;
    } key_pos_t;

    function automatic key_pos_t decode_key(input logic [3:0] code);
        key_pos_t p;
        unique case (code)
            4'd1:  p = '{2'd0, 2'd0};
            4'd2:  p = '{2'd0, 2'd1};
            4'd3:  p = '{2'd0, 2'd2};
            4'd4:  p = '{2'd1, 2'd0};
            4'd5:  p = '{2'd1, 2'd1};
            4'd6:  p = '{2'd1, 2'd2};
            4'd7:  p = '{2'd2, 2'd0};
            4'd8:  p = '{2'd2, 2'd1};
            4'd9:  p = '{2'd2, 2'd2};
            4'd10: p = '{2'd3, 2'd1};
            4'd11: p = '{2'd3, 2'd0};
            4'd12: p = '{2'd3, 2'd2};
            4'd13: p = '{2'd0, 2'd3};
            4'd14: p = '{2'd1, 2'd3};
            4'd15: p = '{2'd2, 2'd3};
            default: p = '{2'd3, 2'd3};
        endcase
        return p;
    endfunction

    function automatic logic [DIV_W-1:0] row_div(input logic [1:0] i);
        unique case (i)
            2'd0: return 8'd160;
            2'd1: return 8'd146;
            2'd2: return 8'd132;
            default: return 8'd118;
        endcase
    endfunction

    function automatic logic [DIV_W-1:0] col_div(input logic [1:0] i);
        unique case (i)
            2'd0: return 8'd92;
            2'd1: return 8'd84;
            2'd2: return 8'd76;
            default: return 8'd68;
        endcase
    endfunction

    // quarter-wave magnitude, index 0..8
    function automatic logic [6:0] quarter_mag(input logic [3:0] i);
        unique case (i)
            4'd0: return 7'd0;
            4'd1: return 7'd25;
            4'd2: return 7'd49;
            4'd3: return 7'd71;
            4'd4: return 7'd90;
            4'd5: return 7'd106;
            4'd6: return 7'd117;
            4'd7: return 7'd125;
            default: return 7'd127;
        endcase
    endfunction

    function automatic logic signed [7:0] sine_lut(input logic [PH_W-1:0] ph);
        logic [3:0] off;
        logic [6:0] m;
        off = ph[3] ? (4'd8 - {1'b0, ph[2:0]}) : {1'b0, ph[2:0]};
        m   = quarter_mag(off);
        return ph[4] ? -$signed({1'b0, m}) : $signed({1'b0, m});
    endfunction
endpackage

// File: rtl/dtmf_tone_chan.sv
module dtmf_tone_chan
    import dtmf_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 clr,
    input  logic [DW-1:0]        div,
    output logic signed [7:0]    sample
);
    logic [DW-1:0]   seg_cnt;
    logic [PH_W-1:0] phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_cnt <= '0;
            phase   <= '0;
        end else if (clr || !en) begin
            seg_cnt <= '0;
            phase   <= '0;
        end else if (seg_cnt == div - 1'b1) begin
            seg_cnt <= '0;
            phase   <= phase + 1'b1;
        end else begin
            seg_cnt <= seg_cnt + 1'b1;
        end
    end

    assign sample = sine_lut(phase);

    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && $past(!clr) && phase != $past(phase)) |-> phase == $past(phase) + 1'b1);
    // R2
    seg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && div != '0) |-> seg_cnt < div);
endmodule

// File: rtl/dtmf_burst_seq.sv
module dtmf_burst_seq
    import dtmf_pkg::*;
#(
    parameter int BURST_CYC = 182557
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic burst_mode,
    input  logic cp_mode,
    output logic tone_window,
    output logic tx_ready
);
    localparam int TMR_W = $clog2(2 * BURST_CYC + 1);
    localparam logic [TMR_W-1:0] LEN_STD = TMR_W'(BURST_CYC);
    localparam logic [TMR_W-1:0] LEN_EXT = TMR_W'(2 * BURST_CYC);

    burst_st_t state, nxt;
    logic [TMR_W-1:0] timer;
    logic [TMR_W-1:0] len;
    logic             last;

    assign len  = cp_mode ? LEN_EXT : LEN_STD;
    assign last = (timer == len - 1'b1);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (burst_mode && wr_en) nxt = ST_BURST;
            ST_BURST: if (!burst_mode) nxt = ST_IDLE;
                      else if (wr_en) nxt = ST_BURST;
                      else if (last)  nxt = ST_PAUSE;
            ST_PAUSE: if (!burst_mode) nxt = ST_IDLE;
                      else if (wr_en) nxt = ST_BURST;
                      else if (last)  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer    <= '0;
            tx_ready <= 1'b0;
        end else begin
            if (wr_en || nxt != state || state == ST_IDLE) timer <= '0;
            else                                           timer <= timer + 1'b1;
            if (!burst_mode || wr_en)          tx_ready <= 1'b0;
            else if (state == ST_PAUSE && last) tx_ready <= 1'b1;
        end
    end

    assign tone_window = (state == ST_BURST);

    // R6
    ready_after_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> $past(state == ST_PAUSE));
    // R8
    ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || !burst_mode) |=> !tx_ready);
    // R7
    timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timer < LEN_EXT);
endmodule

// File: rtl/dtmf_burst_gen.sv
module dtmf_burst_gen
    import dtmf_pkg::*;
#(
    parameter int BURST_CYC = 182557,
    parameter int ROW_GAIN  = 101,
    parameter int SAMP_W    = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [3:0]               wr_code,
    input  logic                     tone_en,
    input  logic                     burst_mode,
    input  logic                     cp_mode,
    input  logic                     single_tone,
    input  logic                     col_sel,
    output logic signed [SAMP_W-1:0] pcm_out,
    output logic                     tx_ready
);
    localparam int PROD_W = 16;
    localparam logic signed [PROD_W-1:0] GAIN = PROD_W'(ROW_GAIN);

    logic [3:0]         code_q;
    key_pos_t           pos;
    logic               tone_window, active, row_en, col_en;
    logic signed [7:0]  row_s, col_s;
    logic signed [PROD_W-1:0] row_prod;
    logic signed [SAMP_W-1:0] row_part, col_part, mix;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     code_q <= '0;
        else if (wr_en) code_q <= wr_code;
    end

    assign pos    = decode_key(code_q);
    assign active = tone_en && (burst_mode ? tone_window : 1'b1);
    assign row_en = active && !(single_tone && col_sel);
    assign col_en = active && !(single_tone && !col_sel);

    dtmf_burst_seq #(.BURST_CYC(BURST_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .burst_mode(burst_mode),
        .cp_mode(cp_mode), .tone_window(tone_window), .tx_ready(tx_ready));

    dtmf_tone_chan u_row (
        .clk(clk), .rst_n(rst_n), .en(row_en), .clr(wr_en),
        .div(row_div(pos.row)), .sample(row_s));

    dtmf_tone_chan u_col (
        .clk(clk), .rst_n(rst_n), .en(col_en), .clr(wr_en),
        .div(col_div(pos.col)), .sample(col_s));

    assign row_prod = $signed({{(PROD_W-8){row_s[7]}}, row_s}) * GAIN;
    assign row_part = row_en ? SAMP_W'(row_prod >>> 7) : '0;
    assign col_part = col_en ? {{(SAMP_W-8){col_s[7]}}, col_s} : '0;
    assign mix      = row_part + col_part;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pcm_out <= '0;
        else if (active) pcm_out <= mix;
        else             pcm_out <= '0;
    end

    // R4
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tone_en |=> pcm_out == '0);
    // R5
    single_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (single_tone && col_sel) |-> row_part == '0);
endmodule

// File: tb/dtmf_burst_gen_test.sv
module dtmf_burst_gen_test;
    localparam int CLK_PER = 10;
    localparam int BL = 300;

    logic clk = 0, rst_n = 0;
    logic wr_en = 0, tone_en = 0, burst_mode = 0, cp_mode = 0, single_tone = 0, col_sel = 0;
    logic [3:0] wr_code = 0;
    logic signed [8:0] pcm_out;
    logic tx_ready;
    int total = 0, bad = 0;

    always #(CLK_PER/2) clk = ~clk;

    dtmf_burst_gen #(.BURST_CYC(BL)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_code(wr_code), .tone_en(tone_en),
        .burst_mode(burst_mode), .cp_mode(cp_mode), .single_tone(single_tone),
        .col_sel(col_sel), .pcm_out(pcm_out), .tx_ready(tx_ready));

    function automatic int sine_ref(input int k);
        return int'(127.0 * $sin(2.0 * 3.14159265358979 * (k % 32) / 32.0));
    endfunction

    function automatic int div_of(input real f);
        return int'(3579545.0 / (32.0 * f));
    endfunction

    function automatic int row_of(input int c);
        if (c >= 1 && c <= 9) return (c - 1) / 3;
        if (c >= 13) return c - 13;
        return 3;
    endfunction

    function automatic int col_of(input int c);
        if (c >= 1 && c <= 9) return (c - 1) % 3;
        if (c == 10) return 1;
        if (c == 11) return 0;
        if (c == 12) return 2;
        return 3;
    endfunction

    function automatic int row_div_ref(input int r);
        real fr [4] = '{699.1, 766.2, 847.4, 948.0};
        return div_of(fr[r]);
    endfunction

    function automatic int col_div_ref(input int c);
        real fc [4] = '{1215.9, 1331.7, 1471.9, 1645.0};
        return div_of(fc[c]);
    endfunction

    // expected sample after edge n (n>=1) following the write edge
    function automatic int expect_pcm(input int code, input bit st, input bit cs, input int n);
        int rs, cv, rv;
        rs = sine_ref((n - 1) / row_div_ref(row_of(code)));
        cv = sine_ref((n - 1) / col_div_ref(col_of(code)));
        rv = (rs * 101) >>> 7;
        if (st && cs)  rv = 0;
        if (st && !cs) cv = 0;
        return rv + cv;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // len = 0: continuous; ready checked only when len > 0
    task automatic run(input int code, input bit st, input bit cs, input bit bm, input bit cp,
                       input bit ten, input int len, input int ncyc, input string req);
        int pe = 0, pa = 0, pex = 0, re = 0, ra = 0, rex = 0, pbad = 0, rbad = 0;
        @(negedge clk);
        single_tone = st; col_sel = cs; burst_mode = bm; cp_mode = cp; tone_en = ten;
        wr_code = 4'(code); wr_en = 1;
        @(negedge clk);
        wr_en = 0;
        for (int n = 1; n <= ncyc; n++) begin
            int e, er;
            @(negedge clk);
            e = (ten && (len == 0 || n <= len)) ? expect_pcm(code, st, cs, n) : 0;
            if (int'(pcm_out) != e && pbad == 0) begin pa = int'(pcm_out); pex = e; end
            if (int'(pcm_out) != e) pbad++;
            if (len > 0) begin
                er = (n >= 2 * len) ? 1 : 0;
                if (int'(tx_ready) != er && rbad == 0) begin ra = int'(tx_ready); rex = er; end
                if (int'(tx_ready) != er) rbad++;
            end
        end
        check(pbad == 0, {req, " pcm"}, pa, pex);
        if (len > 0) check(rbad == 0, {req, " ready"}, ra, rex);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check(pcm_out == 0, "R4 reset pcm", int'(pcm_out), 0);
        check(tx_ready == 0, "R8 reset ready", int'(tx_ready), 0);
        rst_n = 1;
        // R1 R2 R3 R9: all codes, continuous dual tone
        for (int c = 0; c < 16; c++) run(c, 0, 0, 0, 0, 1, 0, 700, "R1 R3 R9 sweep");
        // R2: one full row cycle
        run(1, 0, 0, 0, 0, 1, 0, 32 * 160 + 4, "R2 full cycle");
        // R5 single tone
        run(4, 1, 0, 0, 0, 1, 0, 800, "R5 row only");
        run(4, 1, 1, 0, 0, 1, 0, 800, "R5 col only");
        run(15, 1, 0, 0, 0, 1, 0, 800, "R5 row only");
        run(15, 1, 1, 0, 0, 1, 0, 800, "R5 col only");
        // R4 enable low
        run(5, 0, 0, 0, 0, 0, 0, 300, "R4 disabled");
        // R6 burst
        run(9, 0, 0, 1, 0, 1, BL, 2 * BL + 5, "R6 burst");
        // R8 write clears ready
        @(negedge clk); wr_code = 4'd2; wr_en = 1;
        @(negedge clk); wr_en = 0;
        check(tx_ready == 0, "R8 write clears", int'(tx_ready), 0);
        // R7 extended
        run(0, 0, 0, 1, 1, 1, 2 * BL, 4 * BL + 5, "R7 extended");
        // R10 restart mid burst
        run(3, 0, 0, 1, 0, 1, BL, 150, "R10 first");
        run(14, 0, 0, 1, 0, 1, BL, 2 * BL + 5, "R10 restart");
        // R4 paused while tone_en low: ready still reached
        run(6, 0, 0, 1, 0, 0, BL, 2 * BL + 2, "R4 burst disabled");
        // R8 burst mode off clears ready
        @(negedge clk); burst_mode = 0;
        @(negedge clk);
        check(tx_ready == 0, "R8 burst off clears", int'(tx_ready), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule